// File: doc/BRIEF.md
# Two-Port Semaphore Token Bank

This block holds a small set of single-bit ownership tokens that two independent ports share. Software running behind either port uses a token to claim a shared resource. It writes a request to the token and then reads back whether it has won. The block makes sure that a token never has two owners at once. When the owner gives a token back, the block passes it straight to the other port if that port asked for it while the token was held.

Each port has its own semaphore enable, a write strobe, a token index and a one-bit write value. A write of 0 requests the token and a write of 1 releases it. The read value is combinational. It shows 0 only to the port that owns the addressed token and 1 in every other case. State changes take effect at the clock edge that samples the write.

Top module: `sem_bank`

## Requirements
- R1: After reset all NUM_SEM tokens (default 8, selected by a 3-bit index) are free and no request is pending, so every read on either port returns 1.
- R2: A port that writes 0 (enable=1, write=1) to a free token owns it from the next cycle, and its reads of that token then return 0.
- R3: A read returns 1 to a port that does not own the addressed token, and returns 1 whenever that port's enable is low.
- R4: The two ports never both read 0 from the same token index in the same cycle.
- R5: When both ports write 0 to the same free token in the same cycle, the left port becomes owner and the right port's request stays pending.
- R6: A request for a token that the other port owns is held as pending. When the owner writes 1, ownership moves to the pending port in the next cycle. With no request pending, the token becomes free.
- R7: A write of 1 from a port that does not own the token is ignored, and a repeated write of 0 from the owner changes nothing.
- R8: When the owner releases a token in the same cycle that the other port requests it, the requester owns the token from the next cycle.
- R9: Accesses with the enable low, or with the write strobe low, leave every token unchanged.
- R10: Each token changes only on accesses that carry its own index. Two ports may own different tokens at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_en | input | 1 | Left port semaphore enable |
| l_wr | input | 1 | Left port write strobe |
| l_idx | input | IDX_W | Left port token index |
| l_wdata | input | 1 | Left write value: 0 request, 1 release |
| l_rdata | output | 1 | Left read value: 0 only when left owns the token |
| r_sem_en | input | 1 | Right port semaphore enable |
| r_wr | input | 1 | Right port write strobe |
| r_idx | input | IDX_W | Right port token index |
| r_wdata | input | 1 | Right write value: 0 request, 1 release |
| r_rdata | output | 1 | Right read value: 0 only when right owns the token |

## Verification
Two functions can fall in the same cycle on one token. The first is a request from each port for a free token. The second is a release by the owner while the other port requests. The bench provokes both by driving both ports on the same index before a single clock edge. In the first case it judges that the left port reads 0 and the right port reads 1, and that the right port takes over after the left releases. In the second case it judges that ownership has moved to the requester one cycle later, with no free cycle in between. Crossed releases on two different tokens in one cycle are also driven, and each port must end up owning the token the other gave up.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_t;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
   parameter int NUM_SEM = 8,
   parameter int IDX_W   = $clog2(NUM_SEM)
) (
   input  logic               sem_en,
   input  logic               wr,
   input  logic [IDX_W-1:0]   idx,
   input  logic               wdata,
   output logic [NUM_SEM-1:0] req,
   output logic [NUM_SEM-1:0] rel
);
   logic access;
   assign access = sem_en & wr;

   for (genvar g = 0; g < NUM_SEM; g++) begin : g_line
      logic hit;
      assign hit    = access && (idx == IDX_W'(g));
      assign req[g] = hit & ~wdata;
      assign rel[g] = hit &  wdata;
   end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
   import sem_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_l,
   input  logic rel_l,
   input  logic req_r,
   input  logic rel_r,
   output logic own_l,
   output logic own_r
);
   owner_t own_q, own_d;
   logic   pend_l_q, pend_l_d;
   logic   pend_r_q, pend_r_d;

   always_comb begin
      own_d    = own_q;
      pend_l_d = pend_l_q;
      pend_r_d = pend_r_q;
      case (own_q)
         OWN_NONE: begin
            if (req_l) begin
               own_d    = OWN_LEFT;
               pend_r_d = req_r;
            end else if (req_r) begin
               own_d = OWN_RIGHT;
            end
         end
         OWN_LEFT: begin
            if (rel_l) begin
               own_d    = (pend_r_q | req_r) ? OWN_RIGHT : OWN_NONE;
               pend_r_d = 1'b0;
            end else if (req_r) begin
               pend_r_d = 1'b1;
            end
         end
         OWN_RIGHT: begin
            if (rel_r) begin
               own_d    = (pend_l_q | req_l) ? OWN_LEFT : OWN_NONE;
               pend_l_d = 1'b0;
            end else if (req_l) begin
               pend_l_d = 1'b1;
            end
         end
         default: begin
            own_d    = OWN_NONE;
            pend_l_d = 1'b0;
            pend_r_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_q    <= OWN_NONE;
         pend_l_q <= 1'b0;
         pend_r_q <= 1'b0;
      end else begin
         own_q    <= own_d;
         pend_l_q <= pend_l_d;
         pend_r_q <= pend_r_d;
      end
   end

   assign own_l = (own_q == OWN_LEFT);
   assign own_r = (own_q == OWN_RIGHT);

   assert_free_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_NONE && req_l) |=> (own_q == OWN_LEFT));
   assert_tie_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_NONE && req_l && req_r) |=> pend_r_q);
   assert_handover_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_LEFT && rel_l && pend_r_q) |=> (own_q == OWN_RIGHT));
   assert_foreign_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_RIGHT && rel_l && !rel_r) |=> (own_q == OWN_RIGHT));
   assert_pending_needs_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pend_r_q |-> (own_q == OWN_LEFT));
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_l && !rel_l && !req_r && !rel_r) |=> $stable(own_q));
endmodule

// File: rtl/sem_rd_mux.sv
module sem_rd_mux #(
   parameter int NUM_SEM = 8,
   parameter int IDX_W   = $clog2(NUM_SEM)
) (
   input  logic               sem_en,
   input  logic [IDX_W-1:0]   idx,
   input  logic [NUM_SEM-1:0] owned,
   output logic               rdata
);
   assign rdata = sem_en ? ~owned[idx] : 1'b1;
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
   parameter int NUM_SEM = 8,
   parameter int IDX_W   = $clog2(NUM_SEM)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             l_sem_en,
   input  logic             l_wr,
   input  logic [IDX_W-1:0] l_idx,
   input  logic             l_wdata,
   output logic             l_rdata,
   input  logic             r_sem_en,
   input  logic             r_wr,
   input  logic [IDX_W-1:0] r_idx,
   input  logic             r_wdata,
   output logic             r_rdata
);
   localparam int SPAN = 1 << IDX_W;

   if (NUM_SEM < 2) begin : g_chk_count
      $error("sem_bank: NUM_SEM must be at least 2");
   end
   if (SPAN != NUM_SEM) begin : g_chk_pow2
      $error("sem_bank: NUM_SEM must be a power of two matching IDX_W");
   end

   logic [NUM_SEM-1:0] req_l, rel_l, req_r, rel_r;
   logic [NUM_SEM-1:0] own_l, own_r;

   sem_port_dec #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_l (
      .sem_en(l_sem_en), .wr(l_wr), .idx(l_idx), .wdata(l_wdata),
      .req(req_l), .rel(rel_l)
   );
   sem_port_dec #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_r (
      .sem_en(r_sem_en), .wr(r_wr), .idx(r_idx), .wdata(r_wdata),
      .req(req_r), .rel(rel_r)
   );

   for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
      sem_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .req_l(req_l[g]), .rel_l(rel_l[g]),
         .req_r(req_r[g]), .rel_r(rel_r[g]),
         .own_l(own_l[g]), .own_r(own_r[g])
      );
   end

   sem_rd_mux #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_rd_l (
      .sem_en(l_sem_en), .idx(l_idx), .owned(own_l), .rdata(l_rdata)
   );
   sem_rd_mux #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_rd_r (
      .sem_en(r_sem_en), .idx(r_idx), .owned(own_r), .rdata(r_rdata)
   );

   assert_single_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sem_en && r_sem_en && l_idx == r_idx) |-> (l_rdata || r_rdata));
   assert_disabled_reads_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_sem_en |-> l_rdata) and (!r_sem_en |-> r_rdata));
endmodule

// File: tb/sem_bank_tb_top.sv
`timescale 1ns/1ps
module sem_bank_tb_top;
   localparam int NUM_SEM = 8;
   localparam int IDX_W   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_sem_en = 1'b0, l_wr = 1'b0, l_wdata = 1'b1;
   logic r_sem_en = 1'b0, r_wr = 1'b0, r_wdata = 1'b1;
   logic [IDX_W-1:0] l_idx = '0, r_idx = '0;
   logic l_rdata, r_rdata;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sem_bank #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .l_sem_en(l_sem_en), .l_wr(l_wr), .l_idx(l_idx), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_sem_en(r_sem_en), .r_wr(r_wr), .r_idx(r_idx), .r_wdata(r_wdata), .r_rdata(r_rdata)
   );

   // vector layout: {l_en,l_wr,l_idx,l_d, r_en,r_wr,r_idx,r_d, l_rd_idx, r_rd_idx, exp_l, exp_r}
   function automatic logic [19:0] vec(input logic le, input logic lw, input logic [2:0] li,
                                       input logic ld, input logic re, input logic rw,
                                       input logic [2:0] ri, input logic rd,
                                       input logic [2:0] lq, input logic [2:0] rq,
                                       input logic el, input logic er);
      return {le, lw, li, ld, re, rw, ri, rd, lq, rq, el, er};
   endfunction

   localparam int NV = 18;
   localparam logic [19:0] VECS [NV] = '{
      vec(1,1,2,0, 0,0,0,1, 2,2, 0,1),  // R2 left claims 2
      vec(0,0,0,1, 1,1,2,0, 2,2, 0,1),  // R6 right pending on 2
      vec(1,1,2,1, 0,0,0,1, 2,2, 1,0),  // R6 handover to right
      vec(1,1,2,1, 0,0,0,1, 2,2, 1,0),  // R7 foreign release ignored
      vec(0,0,0,1, 1,1,2,0, 2,2, 1,0),  // R7 owner re-request no-op
      vec(0,0,0,1, 1,1,2,1, 2,2, 1,1),  // R6 release with nothing pending
      vec(1,1,5,0, 1,1,5,0, 5,5, 0,1),  // R5 tie goes left
      vec(1,1,5,1, 0,0,0,1, 5,5, 1,0),  // R5 right pending gets it
      vec(0,0,0,1, 1,1,5,1, 5,5, 1,1),  // R6 back to free
      vec(1,1,0,0, 1,1,7,0, 0,7, 0,0),  // R10 different tokens
      vec(1,1,7,0, 1,1,0,0, 7,0, 1,1),  // R6 crossed pending
      vec(1,1,0,1, 1,1,7,1, 7,0, 0,0),  // R10 crossed handover
      vec(0,1,7,1, 0,1,0,1, 7,0, 0,0),  // R9 enable low write
      vec(1,0,7,1, 1,0,0,1, 7,0, 0,0),  // R9 strobe low
      vec(1,1,7,1, 1,1,0,1, 7,0, 1,1),  // R6 release both
      vec(1,1,3,0, 0,0,0,1, 3,3, 0,1),  // R2 left claims 3
      vec(1,1,3,1, 1,1,3,0, 3,3, 1,0),  // R8 release+request same cycle
      vec(0,0,0,1, 1,1,3,1, 3,3, 1,1)   // R8 right releases
   };

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic set_l(input logic en, input logic wr, input logic [2:0] idx, input logic d);
      l_sem_en = en; l_wr = wr; l_idx = idx; l_wdata = d;
   endtask
   task automatic set_r(input logic en, input logic wr, input logic [2:0] idx, input logic d);
      r_sem_en = en; r_wr = wr; r_idx = idx; r_wdata = d;
   endtask

   task automatic read_both(input logic [2:0] li, input logic [2:0] ri);
      set_l(1, 0, li, 1);
      set_r(1, 0, ri, 1);
      #1;
   endtask

   task automatic clock_write;
      @(posedge clk);
      #1;
   endtask

   task automatic check_all_free(input string tag);
      for (int k = 0; k < NUM_SEM; k++) begin
         read_both(3'(k), 3'(k));
         check(l_rdata, 1'b1, {tag, " left"});
         check(r_rdata, 1'b1, {tag, " right"});
      end
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #200000;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      check_all_free("R1 reset");

      for (int i = 0; i < NV; i++) begin
         logic [19:0] v;
         v = VECS[i];
         set_l(v[19], v[18], v[17:15], v[14]);
         set_r(v[13], v[12], v[11:9], v[8]);
         clock_write();
         read_both(v[7:5], v[4:2]);
         check(l_rdata, v[1], $sformatf("vector %0d left", i));
         check(r_rdata, v[0], $sformatf("vector %0d right", i));
         if (v[7:5] == v[4:2])
            check(l_rdata | r_rdata, 1'b1, $sformatf("R4 vector %0d single owner", i));
      end

      // R3 enable low hides ownership
      set_l(0, 0, 0, 1);
      set_r(1, 1, 4, 0);
      clock_write();
      read_both(4, 4);
      check(r_rdata, 1'b0, "R3 right owns 4");
      check(l_rdata, 1'b1, "R3 left non-owner");
      set_r(0, 0, 4, 1);
      #1;
      check(r_rdata, 1'b1, "R3 enable low reads 1");

      // R10 other tokens unaffected
      for (int k = 0; k < NUM_SEM; k++) begin
         if (k != 4) begin
            read_both(3'(k), 3'(k));
            check(l_rdata & r_rdata, 1'b1, "R10 untouched token free");
         end
      end

      // R1 reset clears owner and pending
      set_l(1, 1, 1, 0);
      set_r(0, 0, 0, 1);
      clock_write();
      set_l(0, 0, 0, 1);
      set_r(1, 1, 1, 0);
      clock_write();
      set_r(0, 0, 0, 1);
      rst_n = 1'b0;
      clock_write();
      rst_n = 1'b1;
      check_all_free("R1 mid reset");
      set_l(1, 1, 1, 0);
      clock_write();
      set_l(1, 1, 1, 1);
      clock_write();
      read_both(1, 1);
      check(r_rdata, 1'b1, "R1 pending cleared by reset");
      check(l_rdata, 1'b1, "R1 token free after release");

      finish_run();
   end
endmodule